// File: doc/BRIEF.md
# Sequential Multiply-Divide Unit with Hi/Lo Result Registers

This block computes either a full-width product or a quotient and remainder from two 32-bit register operands. Both are produced by an iterative datapath that handles one operand bit per clock. The results never go to a general destination. They land in a dedicated pair of registers with fixed placement. For a product, the upper half goes to `hi_q` and the lower half goes to `lo_q`. For a division, the remainder goes to `hi_q` and the quotient goes to `lo_q`. The two register outputs always show the current contents, so a move-from-hi or move-from-lo read is simply a sample of the matching port.

A one-cycle `start` strobe launches an operation. At that edge the block captures `op` (0 = multiply, 1 = divide), `signed_mode` (1 = two's complement, 0 = unsigned) and both operands. The control state machine has three states:
- `ST_IDLE`: the unit waits.
- `ST_RUN`: the unit iterates for 32 cycles and raises `busy`.
- `ST_DONE`: lasts one cycle, during which `done` is high and the fresh results are visible.

The transitions are:
- *launch*: `ST_IDLE` to `ST_RUN` on `start`.
- *iterate*: `ST_RUN` to `ST_RUN` while the step counter is below its last value.
- *complete*: `ST_RUN` to `ST_DONE` on the last step.
- *relaunch*: `ST_DONE` to `ST_RUN` on `start`.
- *retire*: `ST_DONE` to `ST_IDLE` otherwise.

Signed operation works on magnitudes and corrects the signs when the result is written. A divisor of zero still runs the full sequence. It then leaves both result registers untouched and raises `div_zero`.

Top module: `muldiv_hilo`

## Requirements
- R1: While reset is held and in the first cycle after reset, `busy`, `done` and `div_zero` are 0, and `hi_q` and `lo_q` are 0.
- R2: A `start` sampled while `busy` is 0 makes `busy` 1 for exactly 32 cycles. `done` is then 1 for exactly one cycle, and in that cycle `hi_q`/`lo_q` already show the new results.
- R3: With `op`=0 and `signed_mode`=0, the 64-bit unsigned product appears with bits 63..32 in `hi_q` and bits 31..0 in `lo_q`.
- R4: With `op`=0 and `signed_mode`=1, the operands are two's complement and `{hi_q,lo_q}` holds the 64-bit two's-complement product.
- R5: With `op`=1 and `signed_mode`=0, `lo_q` receives the unsigned quotient and `hi_q` the unsigned remainder.
- R6: With `op`=1 and `signed_mode`=1, the quotient is truncated toward zero and the remainder has the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R7: A divide with divisor 0 takes the same 32 busy cycles and `done` pulse. It leaves `hi_q`/`lo_q` unchanged and sets `div_zero` to 1 from the `done` cycle until the next accepted `start`. A multiply by zero never sets it.
- R8: A `start` sampled while `busy` is 1, including in the last busy cycle, is ignored and does not alter the running operation or its result. A `start` sampled in the `done` cycle is accepted.
- R9: `hi_q` and `lo_q` change only in a cycle in which `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, sampled when not busy |
| op | input | 1 | Operation: 0 multiply, 1 divide |
| signed_mode | input | 1 | 1 two's complement, 0 unsigned |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while iterating |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last accepted divide had a zero divisor |
| hi_q | output | 32 | Hi register contents (move-from-hi) |
| lo_q | output | 32 | Lo register contents (move-from-lo) |

## Verification
The interesting collisions happen at the end of an operation.

The first is a new `start` arriving in the last busy cycle, which is the same edge that writes hi/lo. It must be dropped while the result write completes.

The second is a `start` in the `done` cycle. It must launch the next operation while the previous result stays readable. A divide by zero launched that way must also clear `div_zero` on that edge.

The bench provokes these cases by driving `start` with different operands at the last busy cycle and again exactly in the `done` cycle. Every output is judged every clock against a behavioural model that accepts or drops requests purely from its own busy count.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } md_state_e;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic finish,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (W > 2) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    md_state_e state, state_nxt;
    logic [CNT_W-1:0] cnt;

    // state register and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            if (accept)
                cnt <= '0;
            else if (state == ST_RUN)
                cnt <= cnt + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = ST_RUN;
            ST_RUN:  if (cnt == LAST) state_nxt = ST_DONE;
            ST_DONE: state_nxt = start ? ST_RUN : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept = 1'b0;
        finish = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        unique case (state)
            ST_IDLE: accept = start;
            ST_RUN: begin
                busy   = 1'b1;
                finish = (cnt == LAST);
            end
            ST_DONE: begin
                done   = 1'b1;
                accept = start;
            end
            default: ;
        endcase
    end

    assert_done_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy);

endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  md_op_e         op,
    input  logic [W-1:0]   acc,
    input  logic [W-1:0]   rsh,
    input  logic [W-1:0]   dvs,
    output logic [W-1:0]   acc_nxt,
    output logic [W-1:0]   rsh_nxt
);
    logic [W:0] sum;
    logic [W:0] shl;
    logic [W:0] diff;

    always_comb begin
        // shift-add multiply step
        sum  = rsh[0] ? ({1'b0, acc} + {1'b0, dvs}) : {1'b0, acc};
        // restoring divide step
        shl  = {acc, rsh[W-1]};
        diff = shl - {1'b0, dvs};
        unique case (op)
            OP_MUL: begin
                acc_nxt = sum[W:1];
                rsh_nxt = {sum[0], rsh[W-1:1]};
            end
            OP_DIV: begin
                if (!diff[W]) begin
                    acc_nxt = diff[W-1:0];
                    rsh_nxt = {rsh[W-2:0], 1'b1};
                end else begin
                    acc_nxt = shl[W-1:0];
                    rsh_nxt = {rsh[W-2:0], 1'b0};
                end
            end
            default: begin
                acc_nxt = acc;
                rsh_nxt = rsh;
            end
        endcase
    end

endmodule

// File: rtl/muldiv_fix.sv
module muldiv_fix
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  md_op_e        op,
    input  logic          neg_main,
    input  logic          neg_rem,
    input  logic [W-1:0]  acc,
    input  logic [W-1:0]  rsh,
    output logic [W-1:0]  hi_res,
    output logic [W-1:0]  lo_res
);
    logic [2*W-1:0] prod;

    always_comb begin
        prod = {acc, rsh};
        if (neg_main)
            prod = -prod;
        unique case (op)
            OP_MUL: begin
                hi_res = prod[2*W-1:W];
                lo_res = prod[W-1:0];
            end
            OP_DIV: begin
                lo_res = neg_main ? -rsh : rsh;
                hi_res = neg_rem  ? -acc : acc;
            end
            default: begin
                hi_res = '0;
                lo_res = '0;
            end
        endcase
    end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op,
    input  logic          signed_mode,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    output logic          busy,
    output logic          done,
    output logic          div_zero,
    output logic [W-1:0]  hi_q,
    output logic [W-1:0]  lo_q
);
    logic accept, finish;

    md_op_e       op_q;
    logic [W-1:0] acc, rsh, dvs;
    logic [W-1:0] acc_nxt, rsh_nxt;
    logic [W-1:0] hi_res, lo_res;
    logic [W-1:0] mag_a, mag_b;
    logic         neg_main, neg_rem, zero_dvs;

    muldiv_ctrl #(.W(W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .finish (finish),
        .busy   (busy),
        .done   (done)
    );

    muldiv_iter #(.W(W)) u_iter (
        .op      (op_q),
        .acc     (acc),
        .rsh     (rsh),
        .dvs     (dvs),
        .acc_nxt (acc_nxt),
        .rsh_nxt (rsh_nxt)
    );

    muldiv_fix #(.W(W)) u_fix (
        .op       (op_q),
        .neg_main (neg_main),
        .neg_rem  (neg_rem),
        .acc      (acc_nxt),
        .rsh      (rsh_nxt),
        .hi_res   (hi_res),
        .lo_res   (lo_res)
    );

    // operand magnitudes for signed mode
    always_comb begin
        mag_a = (signed_mode && opa[W-1]) ? -opa : opa;
        mag_b = (signed_mode && opb[W-1]) ? -opb : opb;
    end

    // iteration datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_MUL;
            acc      <= '0;
            rsh      <= '0;
            dvs      <= '0;
            neg_main <= 1'b0;
            neg_rem  <= 1'b0;
            zero_dvs <= 1'b0;
        end else if (accept) begin
            op_q     <= md_op_e'(op);
            acc      <= '0;
            rsh      <= mag_a;
            dvs      <= mag_b;
            neg_main <= signed_mode && (opa[W-1] ^ opb[W-1]);
            neg_rem  <= signed_mode && opa[W-1];
            zero_dvs <= (opb == '0);
        end else if (busy) begin
            acc <= acc_nxt;
            rsh <= rsh_nxt;
        end
    end

    // result registers and divide-by-zero flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q     <= '0;
            lo_q     <= '0;
            div_zero <= 1'b0;
        end else if (accept) begin
            div_zero <= 1'b0;
        end else if (finish) begin
            if (op_q == OP_DIV && zero_dvs) begin
                div_zero <= 1'b1;
            end else begin
                hi_q <= hi_res;
                lo_q <= lo_res;
            end
        end
    end

    assert_hilo_only_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(hi_q) || !$stable(lo_q)) |-> done);
    assert_dz_keeps_hilo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> ($stable(hi_q) && $stable(lo_q)));
    assert_dz_only_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> (op_q == OP_DIV));
    assert_rem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q == OP_DIV && dvs != '0) |-> (acc < dvs));

endmodule

// File: tb/muldiv_hilo_tb.sv
module muldiv_hilo_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy, done, div_zero;
    logic [31:0] hi_q, lo_q;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit compare_on = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    muldiv_hilo u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .signed_mode(signed_mode), .opa(opa), .opb(opb),
        .busy(busy), .done(done), .div_zero(div_zero),
        .hi_q(hi_q), .lo_q(lo_q)
    );

    // behavioural reference model
    bit          m_busy, m_done, m_dz, m_pdz, m_div, m_sgn;
    int          m_cnt;
    logic [31:0] m_hi, m_lo, m_rhi, m_rlo;

    always @(posedge clk) begin : model
        bit fin;
        logic [63:0] p;
        logic signed [63:0] sa, sb, sq, sr;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_dz = 0; m_hi = '0; m_lo = '0; m_cnt = 0;
            m_div = 0; m_sgn = 0;
        end else begin
            fin = 0;
            if (m_busy) begin
                if (m_cnt == 31) begin m_busy = 0; fin = 1; end
                else m_cnt++;
            end
            m_done = fin;
            if (fin) begin
                if (m_pdz) m_dz = 1;
                else begin m_hi = m_rhi; m_lo = m_rlo; end
            end
            if (!fin && !m_busy && start) begin
                m_busy = 1; m_cnt = 0; m_dz = 0;
                m_div = op; m_sgn = signed_mode;
                m_pdz = op && (opb == 0);
                sa = signed_mode ? {{32{opa[31]}}, opa} : {32'b0, opa};
                sb = signed_mode ? {{32{opb[31]}}, opb} : {32'b0, opb};
                if (!op) begin
                    p = sa * sb;
                    m_rhi = p[63:32]; m_rlo = p[31:0];
                end else if (opb != 0) begin
                    sq = sa / sb; sr = sa % sb;
                    m_rlo = sq[31:0]; m_rhi = sr[31:0];
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic string res_tag();
        if (m_dz || m_pdz && m_div) return "R7 result";
        if (!m_div) return m_sgn ? "R4 product" : "R3 product";
        return m_sgn ? "R6 divide" : "R5 divide";
    endfunction

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (compare_on) begin
            chk("R2/R8 busy", {31'b0, busy}, {31'b0, m_busy});
            chk("R2 done", {31'b0, done}, {31'b0, m_done});
            chk("R7 div_zero", {31'b0, div_zero}, {31'b0, m_dz});
            chk({res_tag(), " hi R9"}, hi_q, m_hi);
            chk({res_tag(), " lo R9"}, lo_q, m_lo);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic launch(input logic o, input logic s, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start = 1; op = o; signed_mode = s; opa = a; opb = b;
        @(negedge clk);
        start = 0; opa = 32'hDEAD_BEEF; opb = 32'h1234_5678;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run(input logic o, input logic s, input logic [31:0] a, input logic [31:0] b,
                       input string tag, input logic [31:0] ehi, input logic [31:0] elo);
        launch(o, s, a, b);
        wait_done();
        chk({tag, " hi"}, hi_q, ehi);
        chk({tag, " lo"}, lo_q, elo);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 hi", hi_q, 32'd0);
        rst_n = 1;
        compare_on = 1;
        @(negedge clk);
        chk("R1 lo after reset", lo_q, 32'd0);

        run(0, 0, 32'd7, 32'd9, "R3 7*9", 32'd0, 32'd63);
        run(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 max*max", 32'hFFFF_FFFE, 32'h0000_0001);
        run(0, 1, 32'hFFFF_FFF1, 32'd3, "R4 -15*3", 32'hFFFF_FFFF, 32'hFFFF_FFD3);
        run(0, 1, 32'h8000_0000, 32'h8000_0000, "R4 min*min", 32'h4000_0000, 32'h0);
        run(1, 0, 32'd100, 32'd7, "R5 100/7", 32'd2, 32'd14);
        run(1, 0, 32'hFFFF_FFFF, 32'd16, "R5 big/16", 32'd15, 32'h0FFF_FFFF);
        run(1, 1, 32'hFFFF_FFF9, 32'd2, "R6 -7/2", 32'hFFFF_FFFF, 32'hFFFF_FFFD);
        run(1, 1, 32'd7, 32'hFFFF_FFFE, "R6 7/-2", 32'd1, 32'hFFFF_FFFD);
        run(1, 1, 32'h8000_0000, 32'hFFFF_FFFF, "R6 min/-1", 32'd0, 32'h8000_0000);
        run(1, 0, 32'd55, 32'd0, "R7 div by zero keeps", 32'd0, 32'h8000_0000);
        chk("R7 flag", {31'b0, div_zero}, 32'd1);
        run(0, 0, 32'd0, 32'd0, "R7 mul by zero", 32'd0, 32'd0);
        chk("R7 no flag on mul", {31'b0, div_zero}, 32'd0);

        // R8: pokes mid-run and at the last busy cycle, then relaunch in done cycle
        launch(0, 0, 32'd1000, 32'd1000);
        repeat (5) @(negedge clk);
        start = 1; op = 1; opa = 32'd9; opb = 32'd0;
        @(negedge clk);
        start = 0;
        while (u_dut.busy && m_cnt != 31) @(negedge clk);
        start = 1; op = 1; signed_mode = 0; opa = 32'd50; opb = 32'd0;
        @(negedge clk);
        start = 0;
        chk("R8 done after pokes", {31'b0, done}, 32'd1);
        chk("R8 result kept lo", lo_q, 32'd1_000_000);
        // relaunch exactly in the done cycle with a divide by zero
        start = 1; op = 1; signed_mode = 0; opa = 32'd50; opb = 32'd0;
        @(negedge clk);
        start = 0;
        chk("R8 relaunch in done cycle", {31'b0, busy}, 32'd1);
        wait_done();
        chk("R7 flag after relaunch", {31'b0, div_zero}, 32'd1);
        chk("R7 hi kept", hi_q, 32'd0);
        // back-to-back: done-cycle start clears the flag
        start = 1; op = 0; opa = 32'd3; opb = 32'd5;
        @(negedge clk);
        start = 0;
        chk("R7 flag cleared on start", {31'b0, div_zero}, 32'd0);
        wait_done();
        chk("R3 3*5", lo_q, 32'd15);
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule